// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write-cycle interface of a parallel NOR flash and turns sequences of bus writes into single-cycle command strobes. It follows the two-cycle unlock preamble, the command byte that comes after it, and the address/data write that completes a program, buffer-write or erase request. It then raises exactly one strobe for one cycle, with the address and data of the completing write latched alongside it. The flash array and the embedded algorithms are outside the block. A `busy` level and an `opDone` pulse from the embedded engine stand in for them.

A shortcut mode skips the unlock preamble. In this mode a program needs only two writes, and only a small set of command bytes is honoured. The mode is entered either by a three-write sequence or by holding the accelerate input high, and it is left by a two-write exit sequence or by lowering that input. The block also tracks whether the running embedded program is suspended. It accepts a suspend only while the engine is busy, accepts a resume only while suspended, and refuses both while the alternate overlay mode is on.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all six strobes are low, `cmdAddr` and `cmdData` are zero, and `bypassMode` and `suspended` are low.
- R2: Outside the shortcut mode, the writes (AAAh, AAh), (555h, 55h), (AAAh, A0h), (A, D) raise `cmdProgram` for one cycle, in the cycle after the fourth write, with `cmdAddr`=A and `cmdData`=D. Only the low 12 address bits are compared, so any base offset is accepted. At most one strobe is high in any cycle.
- R3: A write that does not match the next expected unlock cycle returns the decoder to idle and issues no command. A later lone A0h and the write that follows it produce nothing.
- R4: Outside the shortcut mode, a third write of 20h at AAAh after the preamble sets `bypassMode` in the cycle after that write. With A5h in place of 20h a buffer write is requested, and with F0h `cmdReset` fires. Any other third byte issues nothing.
- R5: In the shortcut mode, A0h at any address followed by (A, D) raises `cmdProgram` with A and D after just two writes.
- R6: In the shortcut mode, 90h at any address followed by 00h clears `bypassMode`. If the second write is anything other than 00h, the mode stays on.
- R7: In the shortcut mode, only A0h, A5h, 80h, 90h and the unlock preamble start anything. Every other single write, including a lone F0h, raises no strobe and leaves the mode on.
- R8: Outside the shortcut mode, a lone F0h raises `cmdReset`. In the shortcut mode, `cmdReset` needs the full (AAAh, AAh), (555h, 55h), F0h sequence, and the mode stays on afterwards.
- R9: After 80h (in the shortcut mode, or after the preamble otherwise), a following write with data 30h raises `cmdErase` for one sector, with `cmdData`=30h and the write's address. Data 10h raises `cmdErase` for the whole chip with `cmdData`=10h. Any other data cancels the erase.
- R10: A5h (in the shortcut mode, or after the preamble otherwise) followed by (A, D) raises `cmdBufWrite` with A and D.
- R11: A write of B0h raises `cmdSuspend` and sets `suspended` only while `busy` is high and the block is not already suspended. An `opDone` pulse clears `suspended`.
- R12: While suspended, a write of 30h raises `cmdResume` and clears `suspended`. A repeated 30h then does nothing. While `busy` is high and the block is not suspended, every write except B0h is ignored.
- R13: While `overlayOn` is high, neither suspend nor resume is accepted.
- R14: While `accelIn` is high, `bypassMode` is forced on and the exit sequence has no effect. A falling edge on `accelIn` clears `bypassMode` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One bus write cycle is presented this clock |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | DATA_W | Data of the write |
| busy | input | 1 | Embedded operation in progress |
| opDone | input | 1 | One-cycle pulse: embedded operation finished |
| accelIn | input | 1 | Accelerate request; forces the shortcut mode |
| overlayOn | input | 1 | Alternate overlay mode active |
| cmdProgram | output | 1 | One-cycle word program request |
| cmdBufWrite | output | 1 | One-cycle buffer write request |
| cmdErase | output | 1 | One-cycle erase request (data tells sector or chip) |
| cmdSuspend | output | 1 | One-cycle program suspend |
| cmdResume | output | 1 | One-cycle program resume |
| cmdReset | output | 1 | One-cycle reset to read mode |
| cmdAddr | output | ADDR_W | Address latched with the last strobe |
| cmdData | output | DATA_W | Data latched with the last strobe |
| bypassMode | output | 1 | Shortcut mode active |
| suspended | output | 1 | Embedded program suspended |

## Verification
Two complete 256-value sweeps cover the main decode. The first varies the command byte after a correct preamble and then sends a fixed follow-up write, which separates program, buffer write, shortcut entry, reset, and bytes that must fall through silently. The second varies the single write made in the shortcut mode and then sends a fixed follow-up, which separates the four honoured bytes from everything else and catches a stray exit. Directed sequences then break the preamble at each position, shift the base address, and run the erase variants. They also step through suspend, redundant resume, busy-time blocking, the overlay block, and the accelerate edges.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_BUF,
    ST_ERASE,
    ST_EXIT
  } seqState_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic prog;
    logic bufWr;
    logic erase;
    logic susp;
    logic resume;
    logic rst;
  } cmdStrobe_t;

  localparam logic [7:0] CODE_KEY1     = 8'hAA;
  localparam logic [7:0] CODE_KEY2     = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_BUFFER   = 8'hA5;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SHORTCUT = 8'h20;
  localparam logic [7:0] CODE_EXIT1    = 8'h90;
  localparam logic [7:0] CODE_EXIT2    = 8'h00;
  localparam logic [7:0] CODE_RESET    = 8'hF0;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0] CODE_RESUME   = 8'h30;

  localparam logic [11:0] KEY_ADDR_A = 12'hAAA;
  localparam logic [11:0] KEY_ADDR_B = 12'h555;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              opDone,
  input  logic              accelIn,
  input  logic              overlayOn,
  output cmdStrobe_t        strobe,
  output logic              bypassMode,
  output logic              suspended
);

  localparam logic [ADDR_W-1:0] keyMask  = ADDR_W'(12'hFFF);
  localparam logic [ADDR_W-1:0] keyAddrA = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] keyAddrB = ADDR_W'(KEY_ADDR_B);

  seqState_t stateQ, stateD;
  logic bypassQ, bypassD;
  logic suspQ, suspD;
  logic accelQ;
  logic hitA, hitB, suspOk, resumeOk, blocked;

  function automatic logic isCode(input logic [DATA_W-1:0] d, input logic [7:0] c);
    return d == DATA_W'(c);
  endfunction

  always_comb begin
    hitA     = (wrAddr & keyMask) == keyAddrA;
    hitB     = (wrAddr & keyMask) == keyAddrB;
    suspOk   = wrEn && isCode(wrData, CODE_SUSPEND) && busy && !suspQ && !overlayOn;
    resumeOk = wrEn && isCode(wrData, CODE_RESUME) && suspQ && !overlayOn
               && (stateQ == ST_IDLE);
    blocked  = busy || suspQ;

    stateD  = stateQ;
    bypassD = bypassQ;
    suspD   = suspQ;
    strobe  = '0;

    if (suspOk) begin
      strobe.susp = 1'b1;
      suspD       = 1'b1;
      stateD      = ST_IDLE;
    end else if (resumeOk) begin
      strobe.resume = 1'b1;
      suspD         = 1'b0;
    end else if (wrEn && !blocked) begin
      unique case (stateQ)
        ST_IDLE: begin
          if (hitA && isCode(wrData, CODE_KEY1)) stateD = ST_UNL1;
          else if (!bypassQ) begin
            if (isCode(wrData, CODE_RESET)) strobe.rst = 1'b1;
          end else if (isCode(wrData, CODE_PROGRAM)) stateD = ST_PROG;
          else if (isCode(wrData, CODE_BUFFER)) stateD = ST_BUF;
          else if (isCode(wrData, CODE_ERASE)) stateD = ST_ERASE;
          else if (isCode(wrData, CODE_EXIT1)) stateD = ST_EXIT;
        end
        ST_UNL1: stateD = (hitB && isCode(wrData, CODE_KEY2)) ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          stateD = ST_IDLE;
          if (isCode(wrData, CODE_RESET)) strobe.rst = 1'b1;
          else if (!bypassQ && hitA) begin
            if (isCode(wrData, CODE_PROGRAM)) stateD = ST_PROG;
            else if (isCode(wrData, CODE_BUFFER)) stateD = ST_BUF;
            else if (isCode(wrData, CODE_ERASE)) stateD = ST_ERASE;
            else if (isCode(wrData, CODE_SHORTCUT)) bypassD = 1'b1;
          end
        end
        ST_PROG: begin
          strobe.prog = 1'b1;
          stateD      = ST_IDLE;
        end
        ST_BUF: begin
          strobe.bufWr = 1'b1;
          stateD       = ST_IDLE;
        end
        ST_ERASE: begin
          strobe.erase = isCode(wrData, CODE_SECTOR) || isCode(wrData, CODE_CHIP);
          stateD       = ST_IDLE;
        end
        ST_EXIT: begin
          if (isCode(wrData, CODE_EXIT2)) bypassD = 1'b0;
          stateD = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end

    if (opDone) suspD = 1'b0;
    if (accelIn) bypassD = 1'b1;
    else if (accelQ) bypassD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      bypassQ <= 1'b0;
      suspQ   <= 1'b0;
      accelQ  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      bypassQ <= bypassD;
      suspQ   <= suspD;
      accelQ  <= accelIn;
    end
  end

  assign bypassMode = bypassQ;
  assign suspended  = suspQ;

  assert_suspend_needs_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspQ) |-> $past(busy));

  assert_accel_forces_bypass_R14: assert property (@(posedge clk) disable iff (!rstN)
    accelIn |=> bypassQ);

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              cmdProgram,
  output logic              cmdBufWrite,
  output logic              cmdErase,
  output logic              cmdSuspend,
  output logic              cmdResume,
  output logic              cmdReset,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  cmdStrobe_t strobeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
    end else begin
      strobeQ <= strobe;
      if (|strobe) begin
        addrQ <= wrAddr;
        dataQ <= wrData;
      end
    end
  end

  assign cmdProgram  = strobeQ.prog;
  assign cmdBufWrite = strobeQ.bufWr;
  assign cmdErase    = strobeQ.erase;
  assign cmdSuspend  = strobeQ.susp;
  assign cmdResume   = strobeQ.resume;
  assign cmdReset    = strobeQ.rst;
  assign cmdAddr     = addrQ;
  assign cmdData     = dataQ;

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdProgram, cmdBufWrite, cmdErase, cmdSuspend, cmdResume, cmdReset}));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  logic              opDone,
  input  logic              accelIn,
  input  logic              overlayOn,
  output logic              cmdProgram,
  output logic              cmdBufWrite,
  output logic              cmdErase,
  output logic              cmdSuspend,
  output logic              cmdResume,
  output logic              cmdReset,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              bypassMode,
  output logic              suspended
);

  cmdStrobe_t strobe;

  fcd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .opDone(opDone), .accelIn(accelIn), .overlayOn(overlayOn),
    .strobe(strobe), .bypassMode(bypassMode), .suspended(suspended)
  );

  fcd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .cmdProgram(cmdProgram), .cmdBufWrite(cmdBufWrite), .cmdErase(cmdErase),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume), .cmdReset(cmdReset),
    .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  assert_program_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdProgram |-> (cmdData == $past(wrData)) && (cmdAddr == $past(wrAddr)));

  assert_resume_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    cmdResume |-> !suspended);

  assert_overlay_blocks_R13: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSuspend || cmdResume) |-> !$past(overlayOn));

endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [5:0] S_NONE = 6'b000000;
  localparam logic [5:0] S_PROG = 6'b100000;
  localparam logic [5:0] S_BUF  = 6'b010000;
  localparam logic [5:0] S_ERA  = 6'b001000;
  localparam logic [5:0] S_SUSP = 6'b000100;
  localparam logic [5:0] S_RES  = 6'b000010;
  localparam logic [5:0] S_RST  = 6'b000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic busy = 1'b0, opDone = 1'b0, accelIn = 1'b0, overlayOn = 1'b0;
  logic cmdProgram, cmdBufWrite, cmdErase, cmdSuspend, cmdResume, cmdReset;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;
  logic bypassMode, suspended;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;
  logic [5:0] obs;
  logic [AW-1:0] obsAddr;
  logic [DW-1:0] obsData;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .opDone(opDone), .accelIn(accelIn), .overlayOn(overlayOn),
    .cmdProgram(cmdProgram), .cmdBufWrite(cmdBufWrite), .cmdErase(cmdErase),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume), .cmdReset(cmdReset),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .bypassMode(bypassMode), .suspended(suspended)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    obs = {cmdProgram, cmdBufWrite, cmdErase, cmdSuspend, cmdResume, cmdReset};
    obsAddr = cmdAddr;
    obsData = cmdData;
  endtask

  task automatic preamble(input logic [AW-1:0] base);
    doWrite(base | 16'h0AAA, 8'hAA);
    doWrite(base | 16'h0555, 8'h55);
  endtask

  task automatic enterShortcut();
    preamble(16'h0000);
    doWrite(16'h0AAA, 8'h20);
  endtask

  task automatic leaveShortcut();
    doWrite(16'h0042, 8'h90);
    doWrite(16'h0077, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 strobes", {cmdProgram, cmdBufWrite, cmdErase, cmdSuspend, cmdResume, cmdReset}, 0);
    checkEq("R1 addr", cmdAddr, 0);
    checkEq("R1 data", cmdData, 0);
    checkEq("R1 bypass", bypassMode, 0);
    checkEq("R1 suspended", suspended, 0);

    // R2 normal program with base offset
    preamble(16'h5000);
    doWrite(16'h5AAA, 8'hA0);
    checkEq("R2 no early strobe", obs, S_NONE);
    doWrite(16'h1234, 8'h5C);
    checkEq("R2 program strobe", obs, S_PROG);
    checkEq("R2 program addr", obsAddr, 16'h1234);
    checkEq("R2 program data", obsData, 8'h5C);
    @(negedge clk);
    checkEq("R2 one cycle", cmdProgram, 0);

    // R3 broken preambles
    doWrite(16'h0AAA, 8'hAA);
    doWrite(16'h0555, 8'h56);
    doWrite(16'h0AAA, 8'hA0);
    doWrite(16'h0040, 8'h11);
    checkEq("R3 broken second cycle", obs, S_NONE);
    doWrite(16'h0AAB, 8'hAA);
    doWrite(16'h0555, 8'h55);
    doWrite(16'h0AAA, 8'hA0);
    doWrite(16'h0040, 8'h11);
    checkEq("R3 broken first cycle", obs, S_NONE);

    // R4/R8/R10 sweep of third byte in normal mode
    for (int d = 0; d < 256; d++) begin
      logic [5:0] expThird, expNext;
      preamble(16'h0000);
      doWrite(16'h0AAA, 8'(d));
      expThird = (d == 8'hF0) ? S_RST : S_NONE;
      checkEq($sformatf("R4 third byte %0h strobe", d), obs, expThird);
      checkEq($sformatf("R4 third byte %0h bypass", d), bypassMode, (d == 8'h20));
      doWrite(16'h0321, 8'h5A);
      expNext = (d == 8'hA0) ? S_PROG : (d == 8'hA5) ? S_BUF : S_NONE;
      checkEq($sformatf("R10 follow after %0h", d), obs, expNext);
      if (bypassMode) leaveShortcut();
    end

    // R8 lone reset in normal mode
    doWrite(16'h0010, 8'hF0);
    checkEq("R8 normal lone reset", obs, S_RST);

    // R5/R6/R7 sweep of single write in shortcut mode
    enterShortcut();
    checkEq("R4 entered", bypassMode, 1);
    for (int d = 0; d < 256; d++) begin
      logic [5:0] expNext;
      doWrite(16'h0100, 8'(d));
      checkEq($sformatf("R7 lone %0h strobe", d), obs, S_NONE);
      checkEq($sformatf("R7 lone %0h mode", d), bypassMode, 1);
      doWrite(16'h0222, 8'h00);
      expNext = (d == 8'hA0) ? S_PROG : (d == 8'hA5) ? S_BUF : S_NONE;
      checkEq($sformatf("R5 follow after %0h", d), obs, expNext);
      checkEq($sformatf("R6 mode after %0h", d), bypassMode, (d != 8'h90));
      if (!bypassMode) enterShortcut();
    end

    // R5 two-write program with data
    doWrite(16'h0ABC, 8'hA0);
    doWrite(16'h7F01, 8'hC3);
    checkEq("R5 shortcut program", obs, S_PROG);
    checkEq("R5 addr", obsAddr, 16'h7F01);
    checkEq("R5 data", obsData, 8'hC3);

    // R10 buffer write
    doWrite(16'h0000, 8'hA5);
    doWrite(16'h0456, 8'h9E);
    checkEq("R10 buffer strobe", obs, S_BUF);
    checkEq("R10 buffer addr", obsAddr, 16'h0456);

    // R9 erases
    doWrite(16'h0000, 8'h80);
    doWrite(16'h0700, 8'h30);
    checkEq("R9 sector erase", obs, S_ERA);
    checkEq("R9 sector addr", obsAddr, 16'h0700);
    checkEq("R9 sector data", obsData, 8'h30);
    doWrite(16'h0000, 8'h80);
    doWrite(16'h0000, 8'h10);
    checkEq("R9 chip erase", obs, S_ERA);
    checkEq("R9 chip data", obsData, 8'h10);
    doWrite(16'h0000, 8'h80);
    doWrite(16'h0000, 8'h31);
    checkEq("R9 bad confirm", obs, S_NONE);

    // R8 full reset in shortcut mode
    preamble(16'h0000);
    doWrite(16'h0999, 8'hF0);
    checkEq("R8 shortcut full reset", obs, S_RST);
    checkEq("R8 mode kept", bypassMode, 1);

    // R6 exit with wrong second byte
    doWrite(16'h0000, 8'h90);
    doWrite(16'h0000, 8'h01);
    checkEq("R6 bad exit keeps mode", bypassMode, 1);
    leaveShortcut();
    checkEq("R6 exit", bypassMode, 0);

    // R11 suspend gating
    doWrite(16'h0000, 8'hB0);
    checkEq("R11 suspend idle ignored", obs, S_NONE);
    checkEq("R11 not suspended", suspended, 0);
    busy = 1'b1;
    preamble(16'h0000);
    doWrite(16'h0AAA, 8'hA0);
    doWrite(16'h0050, 8'h66);
    checkEq("R12 busy blocks program", obs, S_NONE);
    doWrite(16'h0000, 8'hB0);
    checkEq("R11 suspend strobe", obs, S_SUSP);
    checkEq("R11 suspended", suspended, 1);
    doWrite(16'h0000, 8'hB0);
    checkEq("R11 double suspend", obs, S_NONE);

    // R12 resume and redundant resume
    doWrite(16'h0000, 8'h30);
    checkEq("R12 resume strobe", obs, S_RES);
    checkEq("R12 resumed", suspended, 0);
    doWrite(16'h0000, 8'h30);
    checkEq("R12 redundant resume", obs, S_NONE);

    // R11 opDone clears suspension
    doWrite(16'h0000, 8'hB0);
    checkEq("R11 second suspend", suspended, 1);
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
    checkEq("R11 done clears", suspended, 0);

    // R13 overlay blocks suspend and resume
    overlayOn = 1'b1;
    doWrite(16'h0000, 8'hB0);
    checkEq("R13 suspend refused", obs, S_NONE);
    checkEq("R13 not suspended", suspended, 0);
    overlayOn = 1'b0;
    doWrite(16'h0000, 8'hB0);
    overlayOn = 1'b1;
    doWrite(16'h0000, 8'h30);
    checkEq("R13 resume refused", obs, S_NONE);
    checkEq("R13 still suspended", suspended, 1);
    overlayOn = 1'b0;
    doWrite(16'h0000, 8'h30);
    checkEq("R13 resume after overlay", obs, S_RES);
    busy = 1'b0;

    // R14 accelerate input
    @(negedge clk); accelIn = 1'b1;
    @(negedge clk);
    checkEq("R14 accel forces mode", bypassMode, 1);
    leaveShortcut();
    checkEq("R14 exit ignored", bypassMode, 1);
    doWrite(16'h0000, 8'hA0);
    doWrite(16'h0321, 8'h77);
    checkEq("R14 shortcut program", obs, S_PROG);
    @(negedge clk); accelIn = 1'b0;
    @(negedge clk);
    checkEq("R14 fall clears mode", bypassMode, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule